// File: doc/BRIEF.md
# Parallel Multiply-Reduce Array

This block is the arithmetic core of a convolution or fully connected layer engine. Every clock it can take one bundle of 16 signed Q8.8 activations together with 256 weights, laid out as 16 output lanes of 16 weights each. The activations are shared by all lanes. Each lane multiplies them by its own weights in 16 truncating, saturating multipliers. It reduces the 16 products in a two-stage adder tree and adds the result into a private running sum.

A bundle flagged as the start of a new sum replaces the running sum instead of adding to it. A bundle flagged as the final one sends the sum out, five clocks after that bundle was accepted. On the way out the sum is clamped to 16 bits and, when enabled, passes through an eight-segment piecewise-linear activation. The clamped sum without activation is the form in which partial sums are written back for a later pass over more input channels.

Top module: `mra_array`

## Requirements
- R1: A product keeps bits [23:8] of the full 32-bit signed product, which rounds toward minus infinity. When the result lies outside the 16-bit range, it saturates to 0x7FFF if positive and to 0x8000 if negative.
- R2: Activation i sits in in_x[16*i+15:16*i]. The weight that lane L applies to activation i sits in in_w[16*(16*L+i)+15:16*(16*L+i)]. Every lane uses all 16 shared activations.
- R3: The tree adds the 16 saturated products of a lane exactly at 20 bits, without loss.
- R4: A valid bundle with in_clear set loads the lane's running sum with its tree result. A valid bundle without in_clear adds its tree result to the running sum. Cycles with in_valid low leave the running sum untouched, whatever in_clear, in_last and the data carry.
- R5: out_valid goes high for exactly one cycle, five rising edges after each valid bundle with in_last set. It stays low for every bundle without in_last.
- R6: With act_en low, each out_data lane is its running sum clamped to the range 0x8000..0x7FFF.
- R7: With act_en high, the clamped value v selects segment s = v[15:13]. That segment's slope sits in act_slope[16*s+15:16*s] and its intercept in act_icpt[16*s+15:16*s], both Q8.8. The output is clamp16(floor(v*slope/256) + intercept).
- R8: Bundles accepted on consecutive cycles each give their own result on consecutive cycles.
- R9: Synchronous reset drives out_valid low and out_data to zero, and discards any bundle still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bundle qualifier |
| in_clear | input | 1 | Bundle starts a new running sum |
| in_last | input | 1 | Bundle completes the sum; emit result |
| in_x | input | 256 | 16 shared Q8.8 activations |
| in_w | input | 4096 | 16 lanes x 16 Q8.8 weights |
| act_en | input | 1 | Apply piecewise-linear activation on output |
| act_slope | input | 128 | 8 Q8.8 segment slopes |
| act_icpt | input | 128 | 8 Q8.8 segment intercepts |
| out_valid | output | 1 | One-cycle result qualifier |
| out_data | output | 256 | 16 lanes of Q8.8 results |

## Verification
The assertions rely on act_en, act_slope and act_icpt staying constant while a final bundle moves through the pipeline. The output stage reads them late, so a change mid-flight would mix two settings in one result. The assertions also rely on reset being held for at least one edge before the first bundle. The stimulus changes the activation settings only after the previous result has appeared, and it releases reset before driving any bundle. Operand values are chosen so that product saturation, floor truncation of small negative products and clamping of large sums are all reached.

// File: rtl/mra_pkg.sv
package mra_pkg;
  localparam int unsigned DEF_N_IN   = 16;
  localparam int unsigned DEF_N_LANE = 16;
  localparam int unsigned DEF_DW     = 16;
  localparam int unsigned DEF_FRAC   = 8;
  localparam int unsigned DEF_SUM_W  = 20;
  localparam int unsigned DEF_ACC_W  = 24;
  localparam int unsigned DEF_N_SEG  = 8;
  localparam int unsigned DEF_GROUP  = 4;
  // multiply, group sum, tree sum, accumulate, output
  localparam int unsigned PIPE_LAT   = 5;
endpackage

// File: rtl/mra_mult_row.sv
module mra_mult_row #(
  parameter int unsigned N_IN = 16,
  parameter int unsigned DW   = 16,
  parameter int unsigned FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_IN*DW-1:0]   x,
  input  logic [N_IN*DW-1:0]   w,
  output logic [N_IN*DW-1:0]   prod_q
);
  localparam int unsigned PW = 2 * DW;
  localparam logic signed [PW-1:0] QMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] QMIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [N_IN*DW-1:0] sat_c;

  for (genvar i = 0; i < N_IN; i++) begin : g_mul
    logic signed [PW-1:0] full;
    logic signed [PW-1:0] shf;
    assign full = $signed(x[i*DW +: DW]) * $signed(w[i*DW +: DW]);
    assign shf  = full >>> FRAC;
    assign sat_c[i*DW +: DW] = (shf > QMAX) ? QMAX[DW-1:0] :
                               (shf < QMIN) ? QMIN[DW-1:0] : shf[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= sat_c;
  end

  // R1: a zero activation always yields a zero product one cycle later
  assert_zero_operand_R1: assert property (@(posedge clk) disable iff (rst)
    (x[DW-1:0] == '0) |=> (prod_q[DW-1:0] == '0));
endmodule

// File: rtl/mra_adder_tree.sv
module mra_adder_tree #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned SUM_W = 20,
  parameter int unsigned GROUP = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IN*DW-1:0]       prod,
  output logic signed [SUM_W-1:0]  sum_q
);
  localparam int unsigned NGRP = N_IN / GROUP;
  localparam int TMAX = int'(N_IN) * ((1 << (DW-1)) - 1);
  localparam int TMIN = -int'(N_IN) * (1 << (DW-1));

  logic [NGRP*SUM_W-1:0] grp_c, grp_q;
  logic signed [SUM_W-1:0] tot_c;

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      logic signed [SUM_W-1:0] a;
      a = '0;
      for (int k = 0; k < GROUP; k++) begin
        a = a + SUM_W'($signed(prod[(g*GROUP+k)*DW +: DW]));
      end
      grp_c[g*SUM_W +: SUM_W] = a;
    end
  end

  always_comb begin
    tot_c = '0;
    for (int g = 0; g < NGRP; g++) begin
      tot_c = tot_c + $signed(grp_q[g*SUM_W +: SUM_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q <= '0;
      sum_q <= '0;
    end else begin
      grp_q <= grp_c;
      sum_q <= tot_c;
    end
  end

  // R3: the reduced sum never leaves the span of 16 saturated products
  assert_tree_range_R3: assert property (@(posedge clk) disable iff (rst)
    (sum_q <= TMAX) && (sum_q >= TMIN));
endmodule

// File: rtl/mra_accum.sv
module mra_accum #(
  parameter int unsigned SUM_W = 20,
  parameter int unsigned ACC_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     clr,
  input  logic signed [SUM_W-1:0]  tree,
  output logic signed [ACC_W-1:0]  acc_q
);
  localparam logic signed [ACC_W:0] AMAX = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] AMIN = {2'b11, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] tree_x;
  logic signed [ACC_W:0]   s;
  logic signed [ACC_W-1:0] nxt;

  assign tree_x = {{(ACC_W-SUM_W){tree[SUM_W-1]}}, tree};

  always_comb begin
    s = {acc_q[ACC_W-1], acc_q} + {tree_x[ACC_W-1], tree_x};
    if (clr)            nxt = tree_x;
    else if (s > AMAX)  nxt = AMAX[ACC_W-1:0];
    else if (s < AMIN)  nxt = AMIN[ACC_W-1:0];
    else                nxt = s[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= nxt;
  end

  // R4: idle cycles leave the running sum alone
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/mra_pwl.sv
module mra_pwl #(
  parameter int unsigned DW    = 16,
  parameter int unsigned FRAC  = 8,
  parameter int unsigned N_SEG = 8
) (
  input  logic signed [DW-1:0]   x,
  input  logic [N_SEG*DW-1:0]    slope_v,
  input  logic [N_SEG*DW-1:0]    icpt_v,
  output logic [DW-1:0]          y
);
  localparam int unsigned SB = $clog2(N_SEG);
  localparam int unsigned PW = 2 * DW;
  localparam logic signed [PW:0] YMAX = {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW:0] YMIN = {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};

  logic [SB-1:0]         seg;
  logic signed [DW-1:0]  slope, icpt;
  logic signed [PW-1:0]  prod, shf;
  logic signed [PW:0]    tot;

  always_comb begin
    seg   = x[DW-1 -: SB];
    slope = $signed(slope_v[seg*DW +: DW]);
    icpt  = $signed(icpt_v[seg*DW +: DW]);
    prod  = x * slope;
    shf   = prod >>> FRAC;
    tot   = {shf[PW-1], shf} + (PW+1)'(icpt);
    if (tot > YMAX)      y = YMAX[DW-1:0];
    else if (tot < YMIN) y = YMIN[DW-1:0];
    else                 y = tot[DW-1:0];
  end
endmodule

// File: rtl/mra_lane.sv
module mra_lane #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned FRAC  = 8,
  parameter int unsigned SUM_W = 20,
  parameter int unsigned ACC_W = 24,
  parameter int unsigned N_SEG = 8,
  parameter int unsigned GROUP = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_IN*DW-1:0]   x,
  input  logic [N_IN*DW-1:0]   w,
  input  logic                 acc_en,
  input  logic                 acc_clr,
  input  logic                 fire,
  input  logic                 act_en,
  input  logic [N_SEG*DW-1:0]  slope_v,
  input  logic [N_SEG*DW-1:0]  icpt_v,
  output logic [DW-1:0]        out_q
);
  localparam logic signed [ACC_W-1:0] CMAX = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] CMIN = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [N_IN*DW-1:0]       prod;
  logic signed [SUM_W-1:0]  tree;
  logic signed [ACC_W-1:0]  acc;
  logic signed [DW-1:0]     clamp;
  logic [DW-1:0]            act_y;

  mra_mult_row #(.N_IN(N_IN), .DW(DW), .FRAC(FRAC)) u_mul (
    .clk(clk), .rst(rst), .x(x), .w(w), .prod_q(prod));

  mra_adder_tree #(.N_IN(N_IN), .DW(DW), .SUM_W(SUM_W), .GROUP(GROUP)) u_tree (
    .clk(clk), .rst(rst), .prod(prod), .sum_q(tree));

  mra_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .en(acc_en), .clr(acc_clr), .tree(tree), .acc_q(acc));

  assign clamp = (acc > CMAX) ? CMAX[DW-1:0] :
                 (acc < CMIN) ? CMIN[DW-1:0] : acc[DW-1:0];

  mra_pwl #(.DW(DW), .FRAC(FRAC), .N_SEG(N_SEG)) u_pwl (
    .x(clamp), .slope_v(slope_v), .icpt_v(icpt_v), .y(act_y));

  always_ff @(posedge clk) begin
    if (rst)       out_q <= '0;
    else if (fire) out_q <= act_en ? act_y : clamp;
  end
endmodule

// File: rtl/mra_array.sv
module mra_array import mra_pkg::*; #(
  parameter int unsigned N_IN   = DEF_N_IN,
  parameter int unsigned N_LANE = DEF_N_LANE,
  parameter int unsigned DW     = DEF_DW,
  parameter int unsigned FRAC   = DEF_FRAC,
  parameter int unsigned SUM_W  = DEF_SUM_W,
  parameter int unsigned ACC_W  = DEF_ACC_W,
  parameter int unsigned N_SEG  = DEF_N_SEG,
  parameter int unsigned GROUP  = DEF_GROUP
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_clear,
  input  logic                      in_last,
  input  logic [N_IN*DW-1:0]        in_x,
  input  logic [N_LANE*N_IN*DW-1:0] in_w,
  input  logic                      act_en,
  input  logic [N_SEG*DW-1:0]       act_slope,
  input  logic [N_SEG*DW-1:0]       act_icpt,
  output logic                      out_valid,
  output logic [N_LANE*DW-1:0]      out_data
);
  localparam int unsigned ACC_STG = PIPE_LAT - 3;  // index of accumulate stage
  localparam int unsigned OUT_STG = PIPE_LAT - 2;  // index of output stage
  localparam int unsigned ROW_W   = N_IN * DW;

  logic [OUT_STG:0] vld_sr, lst_sr;
  logic [ACC_STG:0] clr_sr;
  logic             fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_sr    <= '0;
      lst_sr    <= '0;
      clr_sr    <= '0;
      out_valid <= 1'b0;
    end else begin
      vld_sr    <= {vld_sr[OUT_STG-1:0], in_valid};
      lst_sr    <= {lst_sr[OUT_STG-1:0], in_valid & in_last};
      clr_sr    <= {clr_sr[ACC_STG-1:0], in_valid & in_clear};
      out_valid <= fire;
    end
  end

  assign fire = vld_sr[OUT_STG] & lst_sr[OUT_STG];

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    mra_lane #(
      .N_IN(N_IN), .DW(DW), .FRAC(FRAC), .SUM_W(SUM_W),
      .ACC_W(ACC_W), .N_SEG(N_SEG), .GROUP(GROUP)
    ) u_lane (
      .clk(clk), .rst(rst),
      .x(in_x), .w(in_w[l*ROW_W +: ROW_W]),
      .acc_en(vld_sr[ACC_STG]), .acc_clr(clr_sr[ACC_STG]),
      .fire(fire), .act_en(act_en),
      .slope_v(act_slope), .icpt_v(act_icpt),
      .out_q(out_data[l*DW +: DW]));
  end

  // R5: every result traces back to a final bundle accepted PIPE_LAT cycles earlier
  assert_out_from_last_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_last, PIPE_LAT));
endmodule

// File: tb/tb_mra_array.sv
`timescale 1ns/1ps
module tb_mra_array;
  localparam int NI = 16;
  localparam int NL = 16;
  localparam int DW = 16;
  localparam int NS = 8;
  localparam int NV = 10;

  // {act_en, x, w, expected lane value}
  localparam logic [48:0] TBL [NV] = '{
    {1'b0, 16'h0100, 16'h0100, 16'h1000},
    {1'b0, 16'h0200, 16'h0180, 16'h3000},
    {1'b0, 16'hFF00, 16'h0200, 16'hE000},
    {1'b0, 16'h4000, 16'h0400, 16'h7FFF},
    {1'b0, 16'h4000, 16'hFC00, 16'h8000},
    {1'b0, 16'h0001, 16'h0001, 16'h0000},
    {1'b0, 16'hFFFF, 16'h0001, 16'hFFF0},
    {1'b1, 16'h0100, 16'h0100, 16'h1080},
    {1'b1, 16'hFF00, 16'h0200, 16'hFC00},
    {1'b1, 16'h0200, 16'h0180, 16'h7FFF}
  };

  logic clk = 1'b0;
  logic rst, in_valid, in_clear, in_last, act_en, out_valid;
  logic [NI*DW-1:0]    in_x;
  logic [NL*NI*DW-1:0] in_w;
  logic [NS*DW-1:0]    act_slope, act_icpt;
  logic [NL*DW-1:0]    out_data;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mra_array dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_clear(in_clear), .in_last(in_last),
    .in_x(in_x), .in_w(in_w), .act_en(act_en), .act_slope(act_slope),
    .act_icpt(act_icpt), .out_valid(out_valid), .out_data(out_data));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_lanes(logic [15:0] exp, string req);
    bit ok = 1'b1;
    logic [15:0] seen = exp;
    for (int l = 0; l < NL; l++) begin
      if (out_data[l*DW +: DW] !== exp) begin
        ok = 1'b0;
        seen = out_data[l*DW +: DW];
      end
    end
    chk(ok, req, {16'h0, seen}, {16'h0, exp});
  endtask

  task automatic set_x(logic [15:0] v);
    for (int i = 0; i < NI; i++) in_x[i*DW +: DW] = v;
  endtask

  task automatic set_w(logic [15:0] v);
    for (int k = 0; k < NL*NI; k++) in_w[k*DW +: DW] = v;
  endtask

  task automatic send(bit c, bit l);
    in_valid = 1'b1; in_clear = c; in_last = l;
    @(negedge clk);
    in_valid = 1'b0; in_clear = 1'b0; in_last = 1'b0;
  endtask

  // called right after send(): three quiet cycles, then the result (R5)
  task automatic wait_out();
    bit quiet = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (out_valid !== 1'b0) quiet = 1'b0;
    end
    chk(quiet, "R5 early out_valid", {31'h0, ~quiet}, 32'h0);
    @(negedge clk);
    chk(out_valid === 1'b1, "R5 out_valid at latency", {31'h0, out_valid}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_clear = 1'b0; in_last = 1'b0; act_en = 1'b0;
    set_x(16'h0); set_w(16'h0);
    for (int s = 0; s < NS; s++) begin
      act_slope[s*DW +: DW] = (s < 4) ? 16'h0100 : 16'h0020;
      act_icpt[s*DW +: DW]  = 16'h0000;
    end
    act_slope[1*DW +: DW] = 16'h0400;
    act_icpt[0*DW +: DW]  = 16'h0080;
    act_icpt[1*DW +: DW]  = 16'h0100;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk(out_valid === 1'b0, "R9 reset out_valid", {31'h0, out_valid}, 32'h0);
    chk(out_data === '0, "R9 reset out_data", out_data[31:0], 32'h0);

    // vector table: R1 R3 R6 without activation, R7 with it
    for (int k = 0; k < NV; k++) begin
      act_en = TBL[k][48];
      set_x(TBL[k][47:32]);
      set_w(TBL[k][31:16]);
      send(1'b1, 1'b1);
      wait_out();
      chk_lanes(TBL[k][15:0], TBL[k][48] ? "R7 activation" : "R1 R3 R6 product and sum");
    end
    act_en = 1'b0;

    // R2 R6: lane L weights L.0, activations 1.0; lanes 8 and up clamp
    set_x(16'h0100);
    for (int l = 0; l < NL; l++)
      for (int i = 0; i < NI; i++) in_w[(l*NI+i)*DW +: DW] = 16'(l * 256);
    send(1'b1, 1'b1);
    wait_out();
    for (int l = 0; l < NL; l++) begin
      logic [15:0] e;
      e = (l < 8) ? 16'(l * 4096) : 16'h7FFF;
      chk(out_data[l*DW +: DW] === e, "R2 R6 per-lane weights",
          {16'h0, out_data[l*DW +: DW]}, {16'h0, e});
    end

    // R2 R3: activation i = i.0, weights 1.0, sum 120.0
    for (int i = 0; i < NI; i++) in_x[i*DW +: DW] = 16'(i * 256);
    set_w(16'h0100);
    send(1'b1, 1'b1);
    wait_out();
    chk_lanes(16'h7800, "R2 R3 distinct activations");

    // R4 R5: three bundles into one sum, no output before the last
    set_x(16'h0100); set_w(16'h0100);
    send(1'b1, 1'b0);
    send(1'b0, 1'b0);
    send(1'b0, 1'b1);
    wait_out();
    chk_lanes(16'h3000, "R4 accumulate three bundles");

    // R4: an idle cycle carrying data and flags is ignored
    send(1'b1, 1'b0);
    in_clear = 1'b1; in_last = 1'b1; set_x(16'h4000);
    @(negedge clk);
    in_clear = 1'b0; in_last = 1'b0; set_x(16'h0100);
    send(1'b0, 1'b1);
    wait_out();
    chk_lanes(16'h2000, "R4 idle cycle ignored");

    // R4: a clear bundle discards the earlier sum
    set_x(16'h4000);
    send(1'b1, 1'b0);
    set_x(16'h0100);
    send(1'b1, 1'b1);
    wait_out();
    chk_lanes(16'h1000, "R4 clear restarts sum");

    // R8: back-to-back bundles
    set_x(16'h0100); set_w(16'h0100);
    in_valid = 1'b1; in_clear = 1'b1; in_last = 1'b1;
    @(negedge clk);
    set_x(16'h0200); set_w(16'h0180);
    @(negedge clk);
    in_valid = 1'b0; in_clear = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b1, "R8 first result valid", {31'h0, out_valid}, 32'h1);
    chk_lanes(16'h1000, "R8 first result");
    @(negedge clk);
    chk(out_valid === 1'b1, "R8 second result valid", {31'h0, out_valid}, 32'h1);
    chk_lanes(16'h3000, "R8 second result");

    // R9: reset while a final bundle is in flight
    set_x(16'h0100); set_w(16'h0100);
    send(1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_data === '0, "R9 mid-flight reset data", out_data[31:0], 32'h0);
    begin
      bit quiet = 1'b1;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (out_valid !== 1'b0) quiet = 1'b0;
      end
      chk(quiet, "R9 in-flight bundle dropped", {31'h0, ~quiet}, 32'h0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule